// File: doc/BRIEF.md
# Multiplexed Host Bus Mailbox Bridge

This block connects a host that moves address and data over one shared set of eight lines to a small local 8-bit processor. The host first presents an address byte with an address strobe and then a data byte with a data strobe. A direction line chooses between a host write and a host read. Three byte registers keep the two sides apart: the last host address, a byte sent by the host to the local side, and a byte sent by the local side to the host. Two pending flags tell the local processor when a mailbox holds a byte that has not yet been taken.

On the local side, the top three address bits pick one of eight 8 KB blocks. The selection is valid only while the processor clock phase `phi2` is high. Each block has an active-low select line. RAM, ROM and the serial controller take their chip selects from their blocks. Three other blocks give the local processor access to the mailbox registers. The host strobes are asynchronous to the local clock, so they pass through a two-stage synchronizer before they affect any register or flag.

Top module: `mbox_bridge`

## Requirements
- R1: At most one block select in `blk_sel_n` is low at any time. While `phi2` is high, bit k is low exactly when `loc_addr[15:13]` equals k.
- R2: While `phi2` is low, every bit of `blk_sel_n` is high, together with `ram_cs_n`, `rom_cs_n` and `ser_cs_n`.
- R3: `ram_cs_n` follows block 0 (0x0000-0x1FFF), `ser_cs_n` follows block 5 (0xA000-0xBFFF) and `rom_cs_n` follows block 7 (0xE000-0xFFFF). Blocks 1 and 6 drive no device.
- R4: A rising edge of `host_ale` captures `host_ad_i` into the host address register.
- R5: A rising edge of `host_de` while `host_rd` is 0 captures `host_ad_i` into the host-to-local mailbox. A local read in block 4 (0x8000-0x9FFF) returns that mailbox.
- R6: A local read in block 3 (0x6000-0x7FFF) returns the host address register. All registers reset to 0.
- R7: A local write in block 2 (0x4000-0x5FFF) loads `loc_wdata` into the local-to-host mailbox. During a host read (`host_de` and `host_rd` both high), `host_ad_o` carries that mailbox.
- R8: `host_ad_oe` is high only during a host read data phase. It is low during address phases, host writes and idle time.
- R9: `rx_pend` is set by a host write. It is cleared by a local read in block 4 and is 0 after reset.
- R10: `tx_pend` is set by a local write in block 2. It is cleared at the start of a host read and is 0 after reset. A set and a clear in the same cycle leave the flag set.
- R11: Local writes to blocks 3 and 4 change no register. `loc_rdata_oe` is high only for a local read in block 3 or 4, so a read of block 2 leaves the local bus undriven.
- R12: A host strobe edge takes effect after two synchronizer stages. `host_ad_oe` follows the second local clock edge, and the register and flag updates follow the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ad_i | input | 8 | Host multiplexed address/data, inbound |
| host_ad_o | output | 8 | Host data, outbound (0 when not driving) |
| host_ad_oe | output | 1 | Output enable for host_ad_o |
| host_ale | input | 1 | Host address strobe |
| host_de | input | 1 | Host data strobe |
| host_rd | input | 1 | Host direction, 1 = host reads |
| loc_addr | input | 16 | Local address bus |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data (0 when not driving) |
| loc_rdata_oe | output | 1 | Output enable for loc_rdata |
| loc_rw | input | 1 | Local direction, 1 = read |
| phi2 | input | 1 | Processor clock phase, qualifies decode |
| blk_sel_n | output | 8 | Active-low select per 8 KB block |
| ram_cs_n | output | 1 | RAM chip select, active low |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ser_cs_n | output | 1 | Serial controller chip select, active low |
| rx_pend | output | 1 | Host-to-local mailbox holds an unread byte |
| tx_pend | output | 1 | Local-to-host mailbox holds a byte the host has not read |

## Verification
Several properties are checked on every clock cycle:
- The block selects are exclusive and stay inactive while `phi2` is low.
- The local bus is driven only for reads of the two readable windows.
- The host lines are driven only after the host read strobes have been synchronized.
- Each pending flag rises or falls only after the local or host access that may change it.

Other behaviour can only be shown by the bench's scenarios:
- The data paths themselves, for example an address byte reaching a local read.
- Writes to the read-only windows being ignored.
- The exact two-edge and three-edge synchronizer latencies.
- The address-to-block mapping across block boundaries.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int BLK_W  = 3;
    localparam int NBLK   = 1 << BLK_W;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [BLK_W-1:0] {
        BLK_RAM    = 3'd0,
        BLK_FREE1  = 3'd1,
        BLK_TOHOST = 3'd2,
        BLK_HADDR  = 3'd3,
        BLK_FRHOST = 3'd4,
        BLK_SERIAL = 3'd5,
        BLK_FREE6  = 3'd6,
        BLK_ROM    = 3'd7
    } blk_e;

    // Host strobes as one bundle so they share a synchronizer.
    typedef struct packed {
        logic ale;
        logic de;
        logic rd;
    } hstb_t;

    // Local accesses to the mailbox windows.
    typedef struct packed {
        logic rd_haddr;
        logic rd_frhost;
        logic wr_tohost;
    } lacc_t;

    function automatic logic blk_hit(logic [NBLK-1:0] sel_n, blk_e b);
        return ~sel_n[b];
    endfunction
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[s] <= '0;
                end else begin
                    if (s == 0) stg[s] <= d;
                    else        stg[s] <= stg[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mbox_decode.sv
module mbox_decode #(
    parameter int AW = 16,
    parameter int BW = 3,
    localparam int NB = 1 << BW
) (
    input  logic [AW-1:0] addr,
    input  logic          phi2,
    output logic [NB-1:0] sel_n
);
    logic [BW-1:0] blk;
    assign blk = addr[AW-1 -: BW];

    genvar k;
    generate
        for (k = 0; k < NB; k++) begin : g_sel
            assign sel_n[k] = ~(phi2 && (blk == BW'(k)));
        end
    endgenerate
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  hstb_t         hs,
    input  logic [DW-1:0] host_ad_i,
    input  lacc_t         la,
    input  logic [DW-1:0] loc_wdata,
    output logic [DW-1:0] haddr_q,
    output logic [DW-1:0] frhost_q,
    output logic [DW-1:0] host_ad_o,
    output logic          host_ad_oe,
    output logic          rx_pend,
    output logic          tx_pend
);
    hstb_t         hs_d;
    logic [DW-1:0] tohost_q;
    logic          ale_rise, de_rise, hwr, hrd;

    assign ale_rise = hs.ale & ~hs_d.ale;
    assign de_rise  = hs.de  & ~hs_d.de;
    assign hwr      = de_rise & ~hs.rd;
    assign hrd      = de_rise &  hs.rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_d     <= '0;
            haddr_q  <= '0;
            frhost_q <= '0;
            tohost_q <= '0;
            rx_pend  <= 1'b0;
            tx_pend  <= 1'b0;
        end else begin
            hs_d <= hs;
            if (ale_rise)     haddr_q  <= host_ad_i;
            if (hwr)          frhost_q <= host_ad_i;
            if (la.wr_tohost) tohost_q <= loc_wdata;
            if (hwr)               rx_pend <= 1'b1;
            else if (la.rd_frhost) rx_pend <= 1'b0;
            if (la.wr_tohost)      tx_pend <= 1'b1;
            else if (hrd)          tx_pend <= 1'b0;
        end
    end

    assign host_ad_oe = hs.de & hs.rd;
    assign host_ad_o  = host_ad_oe ? tohost_q : '0;
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
    import mbox_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   host_ad_i,
    output logic [DATA_W-1:0]   host_ad_o,
    output logic                host_ad_oe,
    input  logic                host_ale,
    input  logic                host_de,
    input  logic                host_rd,
    input  logic [ADDR_W-1:0]   loc_addr,
    input  logic [DATA_W-1:0]   loc_wdata,
    output logic [DATA_W-1:0]   loc_rdata,
    output logic                loc_rdata_oe,
    input  logic                loc_rw,
    input  logic                phi2,
    output logic [NBLK-1:0]     blk_sel_n,
    output logic                ram_cs_n,
    output logic                rom_cs_n,
    output logic                ser_cs_n,
    output logic                rx_pend,
    output logic                tx_pend
);
    hstb_t             hs_raw, hs_sync;
    lacc_t             la;
    logic [DATA_W-1:0] haddr_q, frhost_q;

    assign hs_raw = '{ale: host_ale, de: host_de, rd: host_rd};

    mbox_sync #(.W($bits(hstb_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (hs_raw),
        .q   (hs_sync)
    );

    mbox_decode #(.AW(ADDR_W), .BW(BLK_W)) u_dec (
        .addr  (loc_addr),
        .phi2  (phi2),
        .sel_n (blk_sel_n)
    );

    assign ram_cs_n = blk_sel_n[BLK_RAM];
    assign rom_cs_n = blk_sel_n[BLK_ROM];
    assign ser_cs_n = blk_sel_n[BLK_SERIAL];

    assign la.rd_haddr  = blk_hit(blk_sel_n, BLK_HADDR)  &  loc_rw;
    assign la.rd_frhost = blk_hit(blk_sel_n, BLK_FRHOST) &  loc_rw;
    assign la.wr_tohost = blk_hit(blk_sel_n, BLK_TOHOST) & ~loc_rw;

    mbox_regs #(.DW(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .hs         (hs_sync),
        .host_ad_i  (host_ad_i),
        .la         (la),
        .loc_wdata  (loc_wdata),
        .haddr_q    (haddr_q),
        .frhost_q   (frhost_q),
        .host_ad_o  (host_ad_o),
        .host_ad_oe (host_ad_oe),
        .rx_pend    (rx_pend),
        .tx_pend    (tx_pend)
    );

    always_comb begin
        loc_rdata_oe = la.rd_haddr | la.rd_frhost;
        if (la.rd_haddr)       loc_rdata = haddr_q;
        else if (la.rd_frhost) loc_rdata = frhost_q;
        else                   loc_rdata = '0;
    end
endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk (
    input logic        clk,
    input logic        rst,
    input logic        host_de,
    input logic        host_rd,
    input logic        host_ad_oe,
    input logic [15:0] loc_addr,
    input logic        loc_rw,
    input logic        phi2,
    input logic        loc_rdata_oe,
    input logic [7:0]  blk_sel_n,
    input logic        rx_pend,
    input logic        tx_pend
);
    logic l_rd4, l_wr2;
    assign l_rd4 = phi2 &&  loc_rw && (loc_addr[15:13] == 3'd4);
    assign l_wr2 = phi2 && !loc_rw && (loc_addr[15:13] == 3'd2);

    a_r1_sel_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~blk_sel_n));

    a_r2_idle_without_phi2: assert property (@(posedge clk) disable iff (rst)
        !phi2 |-> (blk_sel_n == 8'hFF));

    a_r8_host_drive_window: assert property (@(posedge clk) disable iff (rst)
        host_ad_oe |-> ($past(host_de, 2) && $past(host_rd, 2)));

    a_r11_local_drive: assert property (@(posedge clk) disable iff (rst)
        loc_rdata_oe |-> (phi2 && loc_rw &&
                          (loc_addr[15:13] == 3'd3 || loc_addr[15:13] == 3'd4)));

    a_r9_rx_set_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_pend) |-> ($past(host_de, 3) && !$past(host_rd, 3)));

    a_r9_rx_clear_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_pend) |-> $past(l_rd4));

    a_r10_tx_set_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_pend) |-> $past(l_wr2));

    a_r10_tx_clear_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_pend) |-> ($past(host_de, 3) && $past(host_rd, 3)));
endmodule

bind mbox_bridge mbox_bridge_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_de      (host_de),
    .host_rd      (host_rd),
    .host_ad_oe   (host_ad_oe),
    .loc_addr     (loc_addr),
    .loc_rw       (loc_rw),
    .phi2         (phi2),
    .loc_rdata_oe (loc_rdata_oe),
    .blk_sel_n    (blk_sel_n),
    .rx_pend      (rx_pend),
    .tx_pend      (tx_pend)
);

// File: tb/sim_mbox_bridge.sv
module sim_mbox_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  host_ad_i = '0;
    logic [7:0]  host_ad_o;
    logic        host_ad_oe;
    logic        host_ale = 1'b0, host_de = 1'b0, host_rd = 1'b0;
    logic [15:0] loc_addr = '0;
    logic [7:0]  loc_wdata = '0;
    logic [7:0]  loc_rdata;
    logic        loc_rdata_oe;
    logic        loc_rw = 1'b1;
    logic        phi2 = 1'b0;
    logic [7:0]  blk_sel_n;
    logic        ram_cs_n, rom_cs_n, ser_cs_n, rx_pend, tx_pend;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mbox_bridge u0 (
        .clk(clk), .rst(rst), .host_ad_i(host_ad_i), .host_ad_o(host_ad_o),
        .host_ad_oe(host_ad_oe), .host_ale(host_ale), .host_de(host_de),
        .host_rd(host_rd), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_rdata(loc_rdata), .loc_rdata_oe(loc_rdata_oe), .loc_rw(loc_rw),
        .phi2(phi2), .blk_sel_n(blk_sel_n), .ram_cs_n(ram_cs_n),
        .rom_cs_n(rom_cs_n), .ser_cs_n(ser_cs_n), .rx_pend(rx_pend),
        .tx_pend(tx_pend)
    );

    typedef struct packed {
        logic [15:0] a;
        logic        p;
        logic [7:0]  sel;
    } dvec_t;

    localparam int NV = 13;
    localparam dvec_t VECS [NV] = '{
        '{16'h0000, 1'b1, 8'hFE}, '{16'h1FFF, 1'b1, 8'hFE},
        '{16'h2000, 1'b1, 8'hFD}, '{16'h5FFF, 1'b1, 8'hFB},
        '{16'h6000, 1'b1, 8'hF7}, '{16'h9ABC, 1'b1, 8'hEF},
        '{16'hA000, 1'b1, 8'hDF}, '{16'hBFFF, 1'b1, 8'hDF},
        '{16'hC123, 1'b1, 8'hBF}, '{16'hE000, 1'b1, 8'h7F},
        '{16'hFFFF, 1'b1, 8'h7F}, '{16'hFFFF, 1'b0, 8'hFF},
        '{16'h0000, 1'b0, 8'hFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic host_addr(input logic [7:0] v);
        host_ad_i = v; host_ale = 1'b1;
        step(4);
        host_ale = 1'b0;
        step(4);
    endtask

    task automatic loc_write(input logic [15:0] a, input logic [7:0] d);
        loc_addr = a; loc_wdata = d; loc_rw = 1'b0; phi2 = 1'b1;
        #1;
        check("R11 no local drive on write", {31'd0, loc_rdata_oe}, 32'd0);
        step(1);
        phi2 = 1'b0; loc_rw = 1'b1;
    endtask

    task automatic loc_read(input logic [15:0] a, output logic [7:0] d, output logic oe);
        loc_addr = a; loc_rw = 1'b1; phi2 = 1'b1;
        #1;
        d = loc_rdata; oe = loc_rdata_oe;
        step(1);
        phi2 = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic oe;

        step(3);
        rst = 1'b0;
        step(1);

        // reset state
        check("R9 rx_pend reset", {31'd0, rx_pend}, 32'd0);
        check("R10 tx_pend reset", {31'd0, tx_pend}, 32'd0);
        check("R8 host not driven after reset", {31'd0, host_ad_oe}, 32'd0);
        loc_read(16'h6000, d, oe);
        check("R6 address reg reset value", {24'd0, d}, 32'd0);
        check("R6 block3 read drives bus", {31'd0, oe}, 32'd1);

        // decode table
        for (int i = 0; i < NV; i++) begin
            loc_addr = VECS[i].a; phi2 = VECS[i].p;
            #1;
            if (VECS[i].p) check("R1 block select", {24'd0, blk_sel_n}, {24'd0, VECS[i].sel});
            else           check("R2 idle selects", {24'd0, blk_sel_n}, {24'd0, VECS[i].sel});
            check("R3 ram cs", {31'd0, ram_cs_n}, {31'd0, VECS[i].sel[0]});
            check("R3 serial cs", {31'd0, ser_cs_n}, {31'd0, VECS[i].sel[5]});
            check("R3 rom cs", {31'd0, rom_cs_n}, {31'd0, VECS[i].sel[7]});
            if (!VECS[i].p)
                check("R2 chip selects idle", {29'd0, ram_cs_n, ser_cs_n, rom_cs_n}, 32'd7);
            step(1);
        end
        phi2 = 1'b0;

        // host address capture
        host_addr(8'h5A);
        loc_read(16'h6000, d, oe);
        check("R4 R6 host address readback", {24'd0, d}, 32'h5A);

        // host write with latency
        host_ad_i = 8'hC3; host_rd = 1'b0; host_de = 1'b1;
        step(1);
        check("R12 rx_pend after edge 1", {31'd0, rx_pend}, 32'd0);
        step(1);
        check("R12 rx_pend after edge 2", {31'd0, rx_pend}, 32'd0);
        step(1);
        check("R9 R12 rx_pend after edge 3", {31'd0, rx_pend}, 32'd1);
        check("R8 no drive on host write", {31'd0, host_ad_oe}, 32'd0);
        host_de = 1'b0;
        step(4);
        host_ad_i = 8'h00;

        loc_read(16'h8000, d, oe);
        check("R5 host data readback", {24'd0, d}, 32'hC3);
        check("R9 rx_pend cleared by read", {31'd0, rx_pend}, 32'd0);

        // writes to read-only windows ignored
        loc_write(16'h6010, 8'h11);
        loc_write(16'h9000, 8'h22);
        loc_read(16'h7FFF, d, oe);
        check("R11 block3 write ignored", {24'd0, d}, 32'h5A);
        loc_read(16'h8001, d, oe);
        check("R11 block4 write ignored", {24'd0, d}, 32'hC3);
        check("R11 read does not set rx", {31'd0, rx_pend}, 32'd0);

        // local to host
        loc_write(16'h4000, 8'h96);
        check("R10 tx_pend set by local write", {31'd0, tx_pend}, 32'd1);
        loc_read(16'h5FFF, d, oe);
        check("R11 block2 read not driven", {31'd0, oe}, 32'd0);

        host_rd = 1'b1; host_de = 1'b1;
        step(1);
        check("R12 no drive after edge 1", {31'd0, host_ad_oe}, 32'd0);
        step(1);
        check("R7 R12 host read drive", {31'd0, host_ad_oe}, 32'd1);
        check("R7 host read data", {24'd0, host_ad_o}, 32'h96);
        step(1);
        check("R10 tx_pend cleared by host read", {31'd0, tx_pend}, 32'd0);
        host_de = 1'b0;
        step(2);
        check("R8 drive released", {31'd0, host_ad_oe}, 32'd0);
        step(2);
        host_rd = 1'b0;
        step(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule